// File: doc/BRIEF.md
# Sequential Integer Multiply/Divide Unit

This block is a multi-cycle integer arithmetic unit that sits beside a processor's main pipeline. It takes one command at a time with two 32-bit operands and computes one of four results: a signed product, an unsigned product, a signed quotient with remainder, or an unsigned quotient with remainder. Multiplication is shift-and-add. Division is restoring division on operand magnitudes, with the signs corrected at the end. Both use one partial step per clock. The full results go into a pair of result registers, HI and LO. What each register holds depends on the command that produced it.

Software reads HI and LO with two move commands. A move returns its value one cycle after it is accepted, and it is accepted even while an operation is running. A separate low-word multiply command returns only the bottom 32 bits of the product on a write-back port and leaves HI/LO untouched. The unit does no overflow or divide-by-zero checking. A zero divisor still takes the normal number of cycles and gives a defined result.

Top module: `muldiv_unit`

## Requirements
- R1: After synchronous reset, busy, done and mf_valid are low, and both HI and LO read back as zero.
- R2: The command codes on cmd_op are 0 signed multiply, 1 unsigned multiply, 2 signed divide, 3 unsigned divide, 4 read HI, 5 read LO, 6 low-word multiply; code 7 is ignored. An unsigned multiply leaves the upper 32 bits of the 64-bit product in HI and the lower 32 bits in LO.
- R3: A signed multiply treats both operands as two's complement and leaves the 64-bit signed product split across HI (upper) and LO (lower).
- R4: An unsigned divide with a nonzero divisor leaves the remainder in HI and the quotient in LO.
- R5: A signed divide truncates toward zero. The quotient is negated when the operand signs differ, and the remainder takes the dividend's sign. Dividing 0x80000000 by 0xFFFFFFFF gives quotient 0x80000000 and remainder 0.
- R6: A zero divisor raises no error and takes the normal cycle count. Unsigned: quotient 0xFFFFFFFF, remainder = dividend. Signed: remainder = dividend, and the quotient is 0xFFFFFFFF for a non-negative dividend or 1 for a negative one.
- R7: When an arithmetic command is accepted, busy is high for exactly 33 cycles, starting in the cycle after acceptance (32 step cycles plus one sign-fixup cycle). done is high for one cycle: the first cycle in which busy is low again.
- R8: A low-word multiply puts the least significant 32 bits of the product on wb_data in the done cycle and leaves HI and LO unchanged. At all other times wb_data is zero.
- R9: An arithmetic command presented while busy is high is ignored. HI and LO change only in a done cycle, and then they hold the result of the command that was accepted.
- R10: A read-HI or read-LO command is accepted even while busy. mf_valid is high in the following cycle, and mf_data then holds the register's value from before the accepting edge, so a read during an operation returns the previous result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | Command code (see R2) |
| src_a | input | 32 | Multiplicand or dividend |
| src_b | input | 32 | Multiplier or divisor |
| busy | output | 1 | An arithmetic operation is in progress |
| done | output | 1 | One-cycle pulse when an operation completes |
| wb_data | output | 32 | Low product word of a low-word multiply, valid with done |
| mf_valid | output | 1 | mf_data carries a HI or LO read |
| mf_data | output | 32 | Value returned by a move command |

## Verification
The bench targets the magnitude and sign-fixup path. It uses operands at the most negative value, at all ones, and with every combination of signs. A design that negated the remainder by the divisor's sign, or that applied two's-complement overflow checks, would return wrong remainders, or a wrong quotient for 0x80000000 divided by -1. Divide by zero is run for unsigned operands and for signed operands of both signs. This catches a unit that stalls, skips iterations, or builds the quotient bits inverted. The bench also issues commands while the unit is busy: an arithmetic command that restarted the unit or overwrote its operands would leave the wrong result, and a move read that bypassed to the new result, or that the unit refused, would return the wrong value or no valid strobe. Busy is counted cycle by cycle to confirm there are exactly 32 steps plus the fixup.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [2:0] {
        OP_MULT  = 3'd0,
        OP_MULTU = 3'd1,
        OP_DIV   = 3'd2,
        OP_DIVU  = 3'd3,
        OP_MFHI  = 3'd4,
        OP_MFLO  = 3'd5,
        OP_MUL   = 3'd6,
        OP_NONE  = 3'd7
    } md_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } md_state_e;

    // Attributes of the running job, latched at acceptance
    typedef struct packed {
        logic is_div;    // divide (else multiply)
        logic sgn;       // operands are two's complement
        logic low_only;  // write back low product word only
        logic neg_q;     // negate product / quotient at fixup
        logic neg_r;     // negate remainder at fixup
    } md_job_t;

    function automatic logic is_arith(md_op_e op);
        return (op == OP_MULT) || (op == OP_MULTU) || (op == OP_DIV) ||
               (op == OP_DIVU) || (op == OP_MUL);
    endfunction

    function automatic logic is_move(md_op_e op);
        return (op == OP_MFHI) || (op == OP_MFLO);
    endfunction

    function automatic md_job_t job_of(md_op_e op, logic a_neg, logic b_neg);
        md_job_t j;
        j.is_div   = (op == OP_DIV) || (op == OP_DIVU);
        j.sgn      = (op == OP_MULT) || (op == OP_DIV);
        j.low_only = (op == OP_MUL);
        j.neg_q    = j.sgn && (a_neg ^ b_neg);
        j.neg_r    = j.sgn && j.is_div && a_neg;
        return j;
    endfunction

endpackage

// File: rtl/md_ctrl.sv
module md_ctrl
    import muldiv_pkg::*;
#(
    parameter int ITER = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic step,
    output logic fix,
    output logic done
);
    localparam int CW = (ITER > 1) ? $clog2(ITER) : 1;
    localparam logic [CW-1:0] LAST = CW'(ITER - 1);

    md_state_e       state_q;
    logic [CW-1:0]   cnt_q;
    logic            done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        cnt_q   <= '0;
                    end
                end
                ST_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST) state_q <= ST_FIX;
                end
                ST_FIX: begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign step = (state_q == ST_RUN);
    assign fix  = (state_q == ST_FIX);
    assign done = done_q;

    // R7: iterations always start from a cleared count
    p_run_from_zero_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(step) |-> (cnt_q == '0));
    // R7: fixup is followed by done with the unit idle
    p_fix_then_done_r7: assert property (@(posedge clk) disable iff (rst)
        fix |=> (done && !busy));
    // R7: done is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/md_mul_core.sv
module md_mul_core #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   mag_a,
    input  logic [W-1:0]   mag_b,
    output logic [2*W-1:0] prod
);
    localparam int PW = 2 * W;

    logic [W-1:0]  mcand_q;
    logic [PW-1:0] acc_q;
    logic [W:0]    upper_sum;

    // One partial-product addition into the upper half per step
    always_comb begin
        upper_sum = {1'b0, acc_q[PW-1:W]} + (acc_q[0] ? {1'b0, mcand_q} : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q <= '0;
            acc_q   <= '0;
        end else if (load) begin
            mcand_q <= mag_a;
            acc_q   <= {{W{1'b0}}, mag_b};
        end else if (step) begin
            acc_q <= {upper_sum, acc_q[W-1:1]};
        end
    end

    assign prod = acc_q;

    // R2: a freshly loaded accumulator has an empty upper half
    p_load_clear_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> (acc_q[PW-1:W] == '0));

endmodule

// File: rtl/md_div_core.sv
module md_div_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] mag_a,
    input  logic [W-1:0] mag_b,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    logic [W-1:0] dvsr_q;
    logic [W-1:0] rem_q;
    logic [W-1:0] quo_q;
    logic [W:0]   shifted;
    logic [W+1:0] trial;
    logic         went_neg;

    // Restoring step: subtract, and keep the old value if it went negative
    always_comb begin
        shifted  = {rem_q, quo_q[W-1]};
        trial    = {1'b0, shifted} - {2'b00, dvsr_q};
        went_neg = trial[W+1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dvsr_q <= '0;
            rem_q  <= '0;
            quo_q  <= '0;
        end else if (load) begin
            dvsr_q <= mag_b;
            rem_q  <= '0;
            quo_q  <= mag_a;
        end else if (step) begin
            rem_q <= went_neg ? shifted[W-1:0] : trial[W-1:0];
            quo_q <= {quo_q[W-2:0], ~went_neg};
        end
    end

    assign quo = quo_q;
    assign rem = rem_q;

    // R4: the partial remainder never reaches the divisor
    p_rem_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (dvsr_q != '0) |-> (rem_q < dvsr_q));

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    input  logic [2:0]      cmd_op,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] wb_data,
    output logic            mf_valid,
    output logic [XLEN-1:0] mf_data
);
    localparam int PW = 2 * XLEN;
    localparam logic [XLEN-1:0] ONE_X = XLEN'(1);
    localparam logic [PW-1:0]   ONE_P = PW'(1);

    md_op_e          op;
    logic            acc_arith;
    logic            acc_move;
    md_job_t         job_d;
    md_job_t         job_q;
    logic [XLEN-1:0] mag_a;
    logic [XLEN-1:0] mag_b;
    logic            step;
    logic            fix;
    logic [PW-1:0]   prod;
    logic [PW-1:0]   prod_f;
    logic [XLEN-1:0] quo;
    logic [XLEN-1:0] rem;
    logic [XLEN-1:0] quo_f;
    logic [XLEN-1:0] rem_f;
    logic [XLEN-1:0] hi_q;
    logic [XLEN-1:0] lo_q;
    logic            mf_valid_q;
    logic [XLEN-1:0] mf_data_q;
    logic [XLEN-1:0] wb_q;

    // Command acceptance and decode
    always_comb begin
        op        = md_op_e'(cmd_op);
        acc_arith = cmd_valid && !busy && is_arith(op);
        acc_move  = cmd_valid && is_move(op);
        job_d     = job_of(op, src_a[XLEN-1], src_b[XLEN-1]);
        mag_a     = (job_d.sgn && src_a[XLEN-1]) ? (~src_a + ONE_X) : src_a;
        mag_b     = (job_d.sgn && src_b[XLEN-1]) ? (~src_b + ONE_X) : src_b;
    end

    md_ctrl #(.ITER(XLEN)) ctrl_i (
        .clk   (clk),
        .rst   (rst),
        .start (acc_arith),
        .busy  (busy),
        .step  (step),
        .fix   (fix),
        .done  (done)
    );

    md_mul_core #(.W(XLEN)) mul_i (
        .clk   (clk),
        .rst   (rst),
        .load  (acc_arith),
        .step  (step && !job_q.is_div),
        .mag_a (mag_a),
        .mag_b (mag_b),
        .prod  (prod)
    );

    md_div_core #(.W(XLEN)) div_i (
        .clk   (clk),
        .rst   (rst),
        .load  (acc_arith),
        .step  (step && job_q.is_div),
        .mag_a (mag_a),
        .mag_b (mag_b),
        .quo   (quo),
        .rem   (rem)
    );

    // Sign fixup on magnitude results
    always_comb begin
        prod_f = job_q.neg_q ? (~prod + ONE_P) : prod;
        quo_f  = job_q.neg_q ? (~quo + ONE_X) : quo;
        rem_f  = job_q.neg_r ? (~rem + ONE_X) : rem;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            job_q      <= '0;
            hi_q       <= '0;
            lo_q       <= '0;
            mf_valid_q <= 1'b0;
            mf_data_q  <= '0;
            wb_q       <= '0;
        end else begin
            if (acc_arith) job_q <= job_d;
            mf_valid_q <= acc_move;
            if (acc_move) mf_data_q <= (op == OP_MFHI) ? hi_q : lo_q;
            wb_q <= '0;
            if (fix) begin
                if (job_q.low_only) begin
                    wb_q <= prod_f[XLEN-1:0];
                end else if (job_q.is_div) begin
                    hi_q <= rem_f;
                    lo_q <= quo_f;
                end else begin
                    hi_q <= prod_f[PW-1:XLEN];
                    lo_q <= prod_f[XLEN-1:0];
                end
            end
        end
    end

    assign wb_data  = wb_q;
    assign mf_valid = mf_valid_q;
    assign mf_data  = mf_data_q;

    // R10: an accepted move is answered in the next cycle
    p_move_latency_r10: assert property (@(posedge clk) disable iff (rst)
        acc_move |=> mf_valid);
    // R9: HI/LO change only when an operation completes
    p_hilo_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable({hi_q, lo_q}) |-> done);
    // R9: a command arriving during a run does not disturb the job
    p_ignore_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_valid && is_arith(op)) |=> $stable(job_q));
    // R8: the write-back port is quiet outside the done cycle
    p_wb_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !done |-> (wb_data == '0));

endmodule

// File: tb/muldiv_unit_tb_top.sv
`timescale 1ns/1ps
module muldiv_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd7;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic        busy;
    logic        done;
    logic [31:0] wb_data;
    logic        mf_valid;
    logic [31:0] mf_data;

    int n_cmp = 0;
    int n_bad = 0;
    int busy_cyc;
    logic        end_done;
    logic [31:0] end_wb;

    always #2 clk = ~clk;

    muldiv_unit #(.XLEN(32)) dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .src_a(src_a), .src_b(src_b), .busy(busy), .done(done),
        .wb_data(wb_data), .mf_valid(mf_valid), .mf_data(mf_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic start_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; src_a = a; src_b = b;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd7;
    endtask

    task automatic wait_done();
        busy_cyc = 0;
        while (busy === 1'b1 && busy_cyc < 200) begin
            busy_cyc++;
            @(negedge clk);
        end
        end_done = done;
        end_wb   = wb_data;
    endtask

    task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        start_op(op, a, b);
        wait_done();
    endtask

    task automatic rd(input logic [2:0] op, input string req, output logic [31:0] val);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd7;
        chk(req, {31'd0, mf_valid}, 32'd1);
        val = mf_data;
    endtask

    function automatic logic [63:0] ref_mul(input logic sgn, input logic [31:0] a, input logic [31:0] b);
        longint sa, sb;
        if (sgn) begin
            sa = longint'($signed(a));
            sb = longint'($signed(b));
            return 64'(sa * sb);
        end
        return {32'd0, a} * {32'd0, b};
    endfunction

    // returns {remainder, quotient}
    function automatic logic [63:0] ref_div(input logic sgn, input logic [31:0] a, input logic [31:0] b);
        longint sa, sb, q, r;
        if (b == 32'd0) begin
            if (sgn && a[31]) return {a, 32'd1};
            return {a, 32'hFFFF_FFFF};
        end
        if (!sgn) return {a % b, a / b};
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        q = sa / sb;
        r = sa % sb;
        return {r[31:0], q[31:0]};
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 mf_valid", {31'd0, mf_valid}, 32'd0);
        rd(3'd4, "R1 read", v); chk("R1 HI", v, 32'd0);
        rd(3'd5, "R1 read", v); chk("R1 LO", v, 32'd0);
    endtask

    task automatic t_mult(input logic sgn, input logic [31:0] a, input logic [31:0] b);
        logic [63:0] e;
        logic [31:0] v;
        string req;
        req = sgn ? "R3" : "R2";
        e = ref_mul(sgn, a, b);
        run_op(sgn ? 3'd0 : 3'd1, a, b);
        chk(req, {31'd0, end_done}, 32'd1);
        rd(3'd4, req, v); chk(req, v, e[63:32]);
        rd(3'd5, req, v); chk(req, v, e[31:0]);
    endtask

    task automatic t_div(input logic sgn, input logic [31:0] a, input logic [31:0] b, input string req);
        logic [63:0] e;
        logic [31:0] v;
        e = ref_div(sgn, a, b);
        run_op(sgn ? 3'd2 : 3'd3, a, b);
        chk(req, {31'd0, end_done}, 32'd1);
        chk({req, " cycles"}, busy_cyc, 32'd33);
        rd(3'd4, req, v); chk({req, " rem"}, v, e[63:32]);
        rd(3'd5, req, v); chk({req, " quo"}, v, e[31:0]);
    endtask

    task automatic t_timing();
        // R7: busy width and done placement
        run_op(3'd1, 32'd3, 32'd5);
        chk("R7 busy cycles", busy_cyc, 32'd33);
        chk("R7 done on busy fall", {31'd0, end_done}, 32'd1);
        @(negedge clk);
        chk("R7 done one cycle", {31'd0, done}, 32'd0);
        chk("R8 wb zero after done", wb_data, 32'd0);
    endtask

    task automatic t_mul_low(input logic [31:0] a, input logic [31:0] b);
        logic [63:0] e;
        logic [31:0] v;
        // establish known HI/LO first
        run_op(3'd1, 32'h0000_1111, 32'h0002_0000);
        e = ref_mul(1'b0, a, b);
        run_op(3'd6, a, b);
        chk("R8 done", {31'd0, end_done}, 32'd1);
        chk("R8 low word", end_wb, e[31:0]);
        rd(3'd4, "R8", v); chk("R8 HI kept", v, 32'h0000_0000 + 32'h0000_0000 + 32'd0);
        rd(3'd5, "R8", v); chk("R8 LO kept", v, 32'h2222_0000);
    endtask

    task automatic t_ignore_busy();
        logic [63:0] e;
        logic [31:0] v;
        e = ref_mul(1'b0, 32'hDEAD_BEEF, 32'h0000_1234);
        start_op(3'd1, 32'hDEAD_BEEF, 32'h0000_1234);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd3; src_a = 32'd77; src_b = 32'd5;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd7;
        wait_done();
        chk("R9 no restart", busy_cyc, 32'd31);
        rd(3'd4, "R9", v); chk("R9 HI", v, e[63:32]);
        rd(3'd5, "R9", v); chk("R9 LO", v, e[31:0]);
    endtask

    task automatic t_move_busy();
        logic [31:0] v;
        run_op(3'd3, 32'd100, 32'd7);  // HI=2, LO=14
        start_op(3'd1, 32'h0001_0000, 32'h0001_0000); // HI=1, LO=0
        chk("R10 busy during read", {31'd0, busy}, 32'd1);
        rd(3'd4, "R10 valid", v); chk("R10 old HI", v, 32'd2);
        rd(3'd5, "R10 valid", v); chk("R10 old LO", v, 32'd14);
        @(negedge clk);
        chk("R10 valid drops", {31'd0, mf_valid}, 32'd0);
        wait_done();
        rd(3'd4, "R10 valid", v); chk("R10 new HI", v, 32'd1);
        rd(3'd5, "R10 valid", v); chk("R10 new LO", v, 32'd0);
    endtask

    task automatic t_unused_code();
        logic [31:0] v;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd7; src_a = 32'd9; src_b = 32'd9;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R2 code 7 ignored busy", {31'd0, busy}, 32'd0);
        chk("R2 code 7 no move", {31'd0, mf_valid}, 32'd0);
        rd(3'd5, "R2", v); chk("R2 code 7 LO kept", v, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_timing();
        t_mult(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        t_mult(1'b0, 32'h1234_5678, 32'h9ABC_DEF0);
        t_mult(1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        t_mult(1'b1, 32'h8000_0000, 32'h8000_0000);
        t_mult(1'b1, 32'hFFFF_FFF9, 32'd3);
        t_mult(1'b1, 32'h7FFF_FFFF, 32'h8000_0000);
        t_div(1'b0, 32'd100, 32'd7, "R4");
        t_div(1'b0, 32'hFFFF_FFFF, 32'h10, "R4");
        t_div(1'b0, 32'd5, 32'd9, "R4");
        t_div(1'b1, 32'hFFFF_FFF9, 32'd2, "R5");
        t_div(1'b1, 32'd7, 32'hFFFF_FFFE, "R5");
        t_div(1'b1, 32'hFFFF_FFF9, 32'hFFFF_FFFE, "R5");
        t_div(1'b1, 32'h8000_0000, 32'hFFFF_FFFF, "R5");
        t_div(1'b0, 32'd1234, 32'd0, "R6");
        t_div(1'b1, 32'hFFFF_FFFB, 32'd0, "R6");
        t_div(1'b1, 32'd5, 32'd0, "R6");
        t_unused_code_prep();
        t_mul_low(32'h0001_0000, 32'h0001_0003);
        t_ignore_busy();
        t_move_busy();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    task automatic t_unused_code_prep();
        // zero HI/LO with a 0*0 product, then check code 7 has no effect
        run_op(3'd1, 32'd0, 32'd0);
        t_unused_code();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule